// File: doc/BRIEF.md
# Two-Wire Bus Memory Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data) that gives the bus master byte access to a 64K x 8 memory held outside the block. A fast system clock samples both bus lines through synchronizers and finds Start and Stop conditions from edges of SDA while SCL is high. Each byte is shifted in on SCL rising edges. Returned bits change only after SCL falling edges. SDA is never driven high: the block only asserts an open-drain enable that pulls the line low.

A transaction opens with a device byte. This byte names the device type, two select bits, the top memory address bit and the direction. A write transaction loads a 15-bit pointer from two address bytes and then stores each following data byte at once, with no page buffer. A read transaction streams bytes starting at the pointer, with the top address bit taken from the device byte. A random read is a write that is cut short after the address bytes by a repeated Start. The pointer keeps its value between transactions. It steps within its own half of the memory, so the top address bit never changes on its own.

Top module: `twi_mem_slave`

## Requirements
- R1: The device byte (MSB first) is accepted only when bits 7:4 equal 1010 and bits 3:2 equal dev_sel_i. Any other value gets no acknowledge, and SDA stays released until the next Start.
- R2: In the device byte, bit 1 is memory address bit 15 and bit 0 selects read (1) or write (0). After a write device byte come an upper address byte (bit 7 ignored, bits 6:0 are address 14:8), a lower address byte (address 7:0) and data bytes. Each of these bytes is acknowledged by pulling SDA low in the ninth clock.
- R3: A data byte is written to memory, as a single mem_we_o pulse, after its eighth bit and before its acknowledge. A Start or Stop before the eighth bit leaves memory untouched.
- R4: While wp_i is high, data bytes are not acknowledged, are not written, and do not advance the pointer.
- R5: The pointer advances after every stored or transmitted byte, within 15 bits. Address 7FFF is followed by 0000 and FFFF by 8000.
- R6: Read data goes out MSB first, starting right after the device-byte acknowledge. It continues while the master acknowledges and releases SDA after a master no-acknowledge.
- R7: A read with no address bytes starts at the pointer left by the last transaction. A write cut short by a repeated Start after the address bytes sets the start point of the following read.
- R8: A Start at any bit position abandons the transfer in progress and waits for a device byte. A Stop ends any transfer.
- R9: The SDA enable changes only while the synchronized SCL is low.
- R10: mem_we_o is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | When high, SDA is pulled low |
| dev_sel_i | input | 2 | Select value compared with device byte bits 3:2 |
| wp_i | input | 1 | Refuses all data writes when high |
| mem_addr_o | output | 16 | Memory address: bank bit and pointer |
| mem_wdata_o | output | 8 | Byte to be written |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_rdata_i | input | 8 | Synchronous memory read data, one cycle after the address |

## Verification
Every cycle, the embedded properties check that the SDA enable moves only while the synchronized clock is low. They also check that the block stays released when it has nothing to do, that write strobes are single pulses never taken under write protect, and that a write keeps the bank bit. Other behaviour can only be shown by bus scenarios driven by the bench. These include the acceptance or refusal of a device byte and the order in which bits leave the block. They also cover pointer continuity across transactions, wrap at the end of each half of memory, and aborted bytes leaving memory unchanged.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } twi_st_e;
endpackage

// File: rtl/twi_bus_sense.sv
module twi_bus_sense #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_o;
      sda_d  <= sda_o;
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges while SCL stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int PTR_W  = 15,
  parameter int BYTE_W = 8,
  localparam int HI_W  = PTR_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_hi_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic              load_lo_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic              inc_i,
  output logic [PTR_W-1:0]  ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (load_hi_i) ptr_q[PTR_W-1:BYTE_W] <= hi_i;
    else if (load_lo_i) ptr_q[BYTE_W-1:0] <= lo_i;
    else if (inc_i)     ptr_q <= ptr_q + 1'b1;  // wraps inside the bank
  end

  assign ptr_o = ptr_q;

  a_r5_wrap_in_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_hi_i && !load_lo_i && ptr_q == '1) |=> (ptr_q == '0));
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = ADDR_W - 1,
  localparam int HI_W       = PTR_W - BYTE_W,
  localparam int CNT_W      = $clog2(BYTE_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        dev_sel_i,
  input  logic              wp_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACKB = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(BYTE_W + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  twi_st_e st_q, st_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] sh_q;
  logic [BYTE_W-1:0] tx_q, wd_q, rx_byte;
  logic oe_q, ack_q, a15_q, rd_q, we_q;
  logic active, byte_end, load_hi, load_lo, load_tx;
  logic [PTR_W-1:0] ptr;

  twi_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign rx_byte  = {sh_q, sda_s};
  assign active   = !start_det && !stop_det && st_q != ST_IDLE;
  assign byte_end = active && scl_rise && cnt_q == LAST;
  assign load_hi  = byte_end && st_q == ST_AHI;
  assign load_lo  = byte_end && st_q == ST_ALO;

  // state entered once the acknowledge clock ends
  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      ST_DEV:  st_nx = rd_q ? ST_RD : ST_AHI;
      ST_AHI:  st_nx = ST_ALO;
      ST_ALO:  st_nx = ST_WR;
      default: st_nx = st_q;
    endcase
  end

  assign load_tx = active && scl_fall && cnt_q == DONE && st_nx == ST_RD;

  twi_addr_ctr #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_ptr (
    .clk_i, .rst_ni,
    .load_hi_i(load_hi), .hi_i(rx_byte[HI_W-1:0]),
    .load_lo_i(load_lo), .lo_i(rx_byte),
    .inc_i(we_q | load_tx),
    .ptr_o(ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      tx_q  <= '0;
      wd_q  <= '0;
      oe_q  <= 1'b0;
      ack_q <= 1'b0;
      a15_q <= 1'b0;
      rd_q  <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_det || stop_det) begin
        st_q  <= start_det ? ST_DEV : ST_IDLE;
        cnt_q <= '0;
        oe_q  <= 1'b0;
        ack_q <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise) begin
          if (cnt_q < ACKB) begin
            sh_q  <= rx_byte[BYTE_W-2:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              unique case (st_q)
                ST_DEV: begin
                  if (rx_byte[7:4] == DEV_TYPE && rx_byte[3:2] == dev_sel_i) begin
                    ack_q <= 1'b1;
                    a15_q <= rx_byte[1];
                    rd_q  <= rx_byte[0];
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                ST_AHI, ST_ALO: ack_q <= 1'b1;
                ST_WR: begin
                  if (!wp_i) begin
                    we_q  <= 1'b1;
                    wd_q  <= rx_byte;
                    ack_q <= 1'b1;
                  end
                end
                default: ;
              endcase
            end
          end else if (cnt_q == ACKB) begin
            cnt_q <= DONE;
            if (st_q == ST_RD && sda_s) st_q <= ST_IDLE;  // master declined
          end
        end else if (scl_fall) begin
          if (cnt_q == ACKB) begin
            oe_q <= ack_q;
          end else if (cnt_q == DONE) begin
            cnt_q <= '0;
            ack_q <= 1'b0;
            st_q  <= st_nx;
            if (st_nx == ST_RD) begin
              oe_q <= ~mem_rdata_i[BYTE_W-1];
              tx_q <= {mem_rdata_i[BYTE_W-2:0], 1'b0};
            end else begin
              oe_q <= 1'b0;
            end
          end else if (st_q == ST_RD && cnt_q != '0) begin
            oe_q <= ~tx_q[BYTE_W-1];
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_addr_o  = {a15_q, ptr};
  assign mem_wdata_o = wd_q;
  assign mem_we_o    = we_q;

  a_r9_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !$past(scl_s));
  a_r10_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  a_r4_wp_blocks_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !$past(wp_i));
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_o);
  a_r5_bank_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (mem_addr_o[ADDR_W-1] == $past(mem_addr_o[ADDR_W-1])));
  a_r2_ack_in_ninth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(oe_q) && st_q != ST_RD) |-> (cnt_q == ACKB));
endmodule

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;
  localparam int T = 8;
  localparam logic [1:0] SEL = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic sda_oe, we;
  logic [15:0] maddr;
  logic [7:0] wdata, rdata;
  wire sda = m_sda & ~sda_oe;

  int checks = 0, errors = 0;
  logic [14:0] ptr = '0;
  logic we_seen = 1'b0, prev_oe = 1'b0, prev_we = 1'b0, done = 1'b0;
  int r9_bad = 0, r10_bad = 0;
  logic [7:0] ram [int];
  logic [7:0] refm [int];

  always #2 clk = ~clk;

  twi_mem_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda), .sda_oe_o(sda_oe),
    .dev_sel_i(SEL), .wp_i(wp), .mem_addr_o(maddr), .mem_wdata_o(wdata),
    .mem_we_o(we), .mem_rdata_i(rdata)
  );

  function automatic logic [7:0] init_b(int a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] ref_rd(int a);
    return refm.exists(a) ? refm[a] : init_b(a);
  endfunction

  always @(posedge clk) begin
    if (we) ram[int'(maddr)] = wdata;
    rdata <= ram.exists(int'(maddr)) ? ram[int'(maddr)] : init_b(int'(maddr));
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe !== prev_oe && m_scl) r9_bad++;
      if (we && prev_we) r10_bad++;
      if (we) we_seen = 1'b1;
    end
    prev_oe = sda_oe;
    prev_we = we;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    if (!m_scl) begin m_sda = 1'b1; tick(T); m_scl = 1'b1; tick(T); end
    else begin m_sda = 1'b1; tick(T); end
    m_sda = 1'b0; tick(T);
    m_scl = 1'b0; tick(T);
  endtask

  task automatic b_stop();
    m_sda = 1'b0; tick(T);
    m_scl = 1'b1; tick(T);
    m_sda = 1'b1; tick(T);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = v[i]; tick(T);
      m_scl = 1'b1; tick(T);
      m_scl = 1'b0;
    end
    tick(T);
  endtask

  // returns 1 when the slave acknowledged
  task automatic send_byte(input logic [7:0] v, output logic ack, output logic wr);
    we_seen = 1'b0;
    send_bits(v, 8);
    m_sda = 1'b1;
    m_scl = 1'b1; tick(T / 2);
    ack = ~sda;
    wr = we_seen;
    tick(T / 2);
    m_scl = 1'b0; tick(T);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] v);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(T);
      m_scl = 1'b1; tick(T / 2);
      v[i] = sda;
      tick(T / 2);
      m_scl = 1'b0;
    end
    tick(T / 2);
    m_sda = nack; tick(T / 2);
    m_scl = 1'b1; tick(T);
    m_scl = 1'b0; tick(T / 2);
    m_sda = 1'b1; tick(T / 2);
  endtask

  function automatic logic [7:0] devb(logic [1:0] s, logic a15, logic rd);
    return {4'b1010, s, a15, rd};
  endfunction

  task automatic set_addr(input logic [15:0] a, input string req);
    logic ack, wr;
    b_start();
    send_byte(devb(SEL, a[15], 1'b0), ack, wr);
    chk(ack, req, ack, 1);
    send_byte({1'($urandom_range(0, 1)), a[14:8]}, ack, wr);
    chk(ack, "R2 upper address ack", ack, 1);
    send_byte(a[7:0], ack, wr);
    chk(ack, "R2 lower address ack", ack, 1);
    ptr = a[14:0];
  endtask

  task automatic write_txn(input logic [15:0] a, input int n, input logic prot);
    logic ack, wr;
    logic [7:0] d;
    wp = prot;
    set_addr(a, "R2 device write ack");
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack, wr);
      if (prot) begin
        chk(!ack && !wr, "R4 protected byte refused", {ack, wr}, 0);
      end else begin
        chk(ack, "R2 data ack", ack, 1);
        chk(wr, "R3 stored before ack", wr, 1);
        refm[{a[15], ptr}] = d;
        ptr++;
      end
    end
    b_stop();
    wp = 1'b0;
  endtask

  task automatic read_seq(input logic a15, input int n, input string req);
    logic ack;
    logic [7:0] v, e;
    b_start();
    send_byte(devb(SEL, a15, 1'b1), ack, e[0]);
    chk(ack, "R6 device read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      e = ref_rd({16'(a15) << 15} | int'(ptr));
      recv_byte(i == n - 1, v);
      chk(v == e, req, v, e);
      ptr++;
    end
    tick(2);
    chk(!sda_oe, "R6 released after nack", sda_oe, 0);
    b_stop();
  endtask

  task automatic rand_read(input logic [15:0] a, input int n);
    set_addr(a, "R7 random read setup ack");
    read_seq(a[15], n, "R7 random read data");
  endtask

  initial begin
    logic ack, wr;
    logic [7:0] v;
    void'($urandom(32'd4711));
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk(!sda_oe && !we, "R1 reset released", {sda_oe, we}, 0);

    // basic write and readback
    write_txn(16'h1234, 2, 1'b0);
    rand_read(16'h1234, 2);
    read_seq(1'b0, 1, "R7 current address continues");

    // foreign select and foreign type
    b_start();
    send_byte(devb(2'b01, 1'b0, 1'b0), ack, wr);
    chk(!ack, "R1 wrong select refused", ack, 0);
    send_byte(8'h00, ack, wr);
    chk(!ack && !wr && !sda_oe, "R1 ignored until start", {ack, wr}, 0);
    b_start();
    send_byte(8'hB0 | {4'h0, SEL, 2'b00}, ack, wr);
    chk(!ack, "R1 wrong type refused", ack, 0);
    b_stop();

    // write protect keeps data and pointer
    write_txn(16'h0100, 2, 1'b1);
    read_seq(1'b0, 1, "R4 pointer and data unchanged");

    // bank wrap on both halves
    write_txn(16'h7FFF, 2, 1'b0);
    rand_read(16'h0000, 1);
    chk(ref_rd(0) == refm[0], "R5 low bank wrap stored", ref_rd(0), refm[0]);
    write_txn(16'hFFFF, 2, 1'b0);
    rand_read(16'hFFFE, 3);
    rand_read(16'h7FFE, 3);

    // aborted bytes leave memory unchanged
    set_addr(16'h2000, "R3 abort setup ack");
    we_seen = 1'b0;
    send_bits(8'hFF, 4);
    b_start();
    send_byte(devb(SEL, 1'b0, 1'b1), ack, wr);
    chk(ack && !we_seen, "R3 start before 8th bit", {ack, we_seen}, 2);
    recv_byte(1'b1, v);
    chk(v == init_b(16'h2000), "R3 memory untouched after start", v, init_b(16'h2000));
    ptr++;
    b_stop();
    set_addr(16'h2100, "R3 abort setup ack");
    we_seen = 1'b0;
    send_bits(8'h00, 5);
    b_stop();
    chk(!we_seen, "R3 stop before 8th bit", we_seen, 0);
    rand_read(16'h2100, 1);

    // start inside an address byte
    ptr = 15'h2101;
    b_start();
    send_byte(devb(SEL, 1'b0, 1'b0), ack, wr);
    send_bits(8'h55, 3);
    b_start();
    send_byte(devb(SEL, 1'b0, 1'b1), ack, wr);
    chk(ack, "R8 new device byte after start", ack, 1);
    recv_byte(1'b1, v);
    chk(v == ref_rd(int'(ptr)), "R8 pointer kept after abort", v, ref_rd(int'(ptr)));
    ptr++;
    b_stop();

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int op = $urandom_range(0, 3);
      logic [15:0] a = 16'($urandom);
      int n = $urandom_range(1, 4);
      case (op)
        0: write_txn(a, n, $urandom_range(0, 4) == 0);
        1: rand_read(a, n);
        2: read_seq(1'($urandom_range(0, 1)), n, "R7 current read data");
        default: begin
          b_start();
          send_byte(devb(~SEL, a[15], a[0]), ack, wr);
          chk(!ack, "R1 random foreign select", ack, 0);
          b_stop();
        end
      endcase
    end

    chk(r9_bad == 0, "R9 enable moved with SCL high", r9_bad, 0);
    chk(r10_bad == 0, "R10 strobe longer than a cycle", r10_bad, 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 190000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule